// File: doc/BRIEF.md
# Command-Byte Register Access Controller

This block stands between a byte-level two-wire target engine and the register file of a colour light sensor. The engine reports three events: a transaction has started, a byte has been written, and a byte is requested for reading. The first written byte of a transaction can be a command byte. It carries a flag bit, a two-bit access type and a five-bit field. For a register access that field is an address, and for a special function it is a function code. The stored address is kept between transactions, so a later read or write with no command byte reuses it.

The block holds the configuration registers and drives their fields onto output ports for the rest of the sensor. It captures four 16-bit conversion results when a conversion completes, and it keeps a pending-interrupt flag. Reading the low byte of a result copies that channel's high byte into a per-channel shadow, so a following high-byte read stays coherent even if a new conversion lands between the two reads. A special-function command clears the pending interrupt.

The sequencer has three states. `ST_CMD_WAIT` is entered on reset and on every transaction start. In this state a written byte with bit 7 set is decoded as a command. A register command (type 00 or 01) moves to `ST_STREAM`. A special or reserved command (type 11 or 10) moves to `ST_HOLD`. A written byte with bit 7 clear is stored as data and moves to `ST_STREAM`. In `ST_STREAM` every written byte is data. In `ST_HOLD` written bytes are discarded. A transaction start returns both `ST_STREAM` and `ST_HOLD` to `ST_CMD_WAIT`.

Top module: `cmd_regctl`

## Requirements
- R1: After reset, the integration-time (0x01) and wait-time (0x03) registers read 0xFF. The identity register (0x12) reads the DEV_ID parameter. All other registers read 0x00, and `irq` is low.
- R2: Only the first byte written after `txn_start` can be a command, and only when its bit 7 is 1. A first byte with bit 7 at 0, and every later byte in a register-access transaction, is written to the stored address.
- R3: Access type 00 (bits 6:5) keeps the stored address unchanged across every data write and read.
- R4: Access type 01 adds one to the stored address after each data write or read, and the address wraps from 0x1F to 0x00.
- R5: Access type 11 with code 00110 clears the pending interrupt. Code 00000, other codes and type 10 have no effect. None of these commands changes the stored address, and data bytes that follow them in the same transaction are discarded.
- R6: A read in a transaction that has no command byte returns the register at the address left by earlier transactions.
- R7: Reading a result low byte (0x14, 0x16, 0x18 or 0x1A) copies that channel's current high byte into its shadow. A read of the high byte (the next address) returns the shadow, even after a later conversion.
- R8: A `conv_done` strobe loads the four results into registers. The channels are clear, red, green and blue, each a little-endian pair starting at 0x14. The same strobe sets status bit 0.
- R9: An `event_set` strobe sets a pending flag that reads as status (0x13) bit 4. `irq` equals that flag ANDed with enable bit 4. The flag stays set until it is cleared as in R5.
- R10: Writes to 0x12, 0x13, the result addresses and unmapped addresses have no effect, and unmapped addresses read 0x00.
- R11: Enable (0x00) bit 4 drives `cfg_irq_en`, bit 3 `cfg_wait_en`, bit 1 `cfg_conv_en` and bit 0 `cfg_power_on`. 0x0C bits 3:0 drive the persistence field, 0x0D bit 1 drives the long-wait flag, and 0x0F bits 1:0 drive the gain. 0x04/0x05 form the low threshold and 0x06/0x07 the high threshold, each low byte first. Reserved bits read 0.
- R12: `rd_byte` shows the requested byte from the clock edge that samples `rd_stb`, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| txn_start | input | 1 | Transaction start strobe |
| wr_stb | input | 1 | Written byte strobe |
| wr_byte | input | 8 | Written byte |
| rd_stb | input | 1 | Read request strobe |
| rd_byte | output | 8 | Read byte, registered |
| conv_done | input | 1 | Conversion complete strobe |
| conv_result | input | CHAN_N*16 | Results, channel 0 (clear) in the low bits |
| event_set | input | 1 | Out-of-range event from the threshold filter |
| cfg_power_on | output | 1 | Power-on field |
| cfg_conv_en | output | 1 | Conversion enable |
| cfg_wait_en | output | 1 | Wait enable |
| cfg_irq_en | output | 1 | Interrupt enable |
| cfg_int_time | output | 8 | Integration time |
| cfg_wait_time | output | 8 | Wait time |
| cfg_wait_long | output | 1 | Long-wait flag |
| cfg_low_thr | output | 16 | Low threshold |
| cfg_high_thr | output | 16 | High threshold |
| cfg_persist | output | 4 | Persistence code |
| cfg_gain | output | 2 | Gain code |
| irq | output | 1 | Interrupt output |

## Verification
The hardest case to reach is a conversion completing between the low-byte read and the high-byte read of one result pair. In that case the shadow must hide the new high byte. The bench opens an auto-increment read at 0x14 and reads the low byte. It then pulses `conv_done` with a different value before issuing the second read strobe, and checks that the old high byte is returned. A fresh pair read afterwards must return the new value. Commands that are dropped are observed through the interrupt pin and through readback of the stored address.

// File: rtl/cmd_regctl_pkg.sv
package cmd_regctl_pkg;

    localparam int BYTE_W = 8;
    localparam int ADR_W  = 5;

    typedef enum logic [1:0] {
        ACC_REPEAT  = 2'b00,
        ACC_INCR    = 2'b01,
        ACC_RSVD    = 2'b10,
        ACC_SPECIAL = 2'b11
    } acc_mode_e;

    typedef enum logic [1:0] {
        ST_CMD_WAIT = 2'b00,
        ST_STREAM   = 2'b01,
        ST_HOLD     = 2'b10
    } seq_state_e;

    localparam logic [ADR_W-1:0] A_ENABLE   = 5'h00;
    localparam logic [ADR_W-1:0] A_ITIME    = 5'h01;
    localparam logic [ADR_W-1:0] A_WTIME    = 5'h03;
    localparam logic [ADR_W-1:0] A_LTHR_LO  = 5'h04;
    localparam logic [ADR_W-1:0] A_LTHR_HI  = 5'h05;
    localparam logic [ADR_W-1:0] A_HTHR_LO  = 5'h06;
    localparam logic [ADR_W-1:0] A_HTHR_HI  = 5'h07;
    localparam logic [ADR_W-1:0] A_PERSIST  = 5'h0C;
    localparam logic [ADR_W-1:0] A_WLONG    = 5'h0D;
    localparam logic [ADR_W-1:0] A_GAIN     = 5'h0F;
    localparam logic [ADR_W-1:0] A_IDENT    = 5'h12;
    localparam logic [ADR_W-1:0] A_STATUS   = 5'h13;
    localparam logic [ADR_W-1:0] A_RES_BASE = 5'h14;

    localparam logic [ADR_W-1:0] FN_NOP     = 5'h00;
    localparam logic [ADR_W-1:0] FN_IRQ_CLR = 5'h06;

endpackage

// File: rtl/cmd_seq.sv
module cmd_seq
    import cmd_regctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              rd_stb,
    output logic              data_we,
    output logic              irq_clr,
    output logic [ADR_W-1:0]  ptr
);

    seq_state_e state_q, state_cur, state_nxt;
    acc_mode_e  mode_q;
    acc_mode_e  cmd_type;
    logic [ADR_W-1:0] cmd_field;
    logic is_cmd;
    logic reg_cmd;
    logic step;

    // a start in the same cycle as a byte makes that byte the first one
    always_comb begin
        state_cur = txn_start ? ST_CMD_WAIT : state_q;
        cmd_type  = acc_mode_e'(wr_byte[6:5]);
        cmd_field = wr_byte[ADR_W-1:0];
        is_cmd    = wr_stb && (state_cur == ST_CMD_WAIT) && wr_byte[BYTE_W-1];
        reg_cmd   = is_cmd && ((cmd_type == ACC_REPEAT) || (cmd_type == ACC_INCR));
    end

    // next-state logic
    always_comb begin
        state_nxt = state_cur;
        unique case (state_cur)
            ST_CMD_WAIT: begin
                if (wr_stb) begin
                    if (!wr_byte[BYTE_W-1] || reg_cmd)
                        state_nxt = ST_STREAM;
                    else
                        state_nxt = ST_HOLD;
                end
            end
            ST_STREAM: state_nxt = ST_STREAM;
            ST_HOLD:   state_nxt = ST_HOLD;
            default:   state_nxt = ST_CMD_WAIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_CMD_WAIT;
        else
            state_q <= state_nxt;
    end

    // outputs
    always_comb begin
        data_we = wr_stb && !is_cmd && (state_cur != ST_HOLD);
        irq_clr = is_cmd && (cmd_type == ACC_SPECIAL) && (cmd_field == FN_IRQ_CLR);
        step    = (data_we || rd_stb) && (mode_q == ACC_INCR);
    end

    // address pointer and access mode persist across transactions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr    <= '0;
            mode_q <= ACC_REPEAT;
        end else if (reg_cmd) begin
            ptr    <= cmd_field;
            mode_q <= cmd_type;
        end else if (step) begin
            ptr    <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/res_shadow.sv
module res_shadow
    import cmd_regctl_pkg::*;
#(
    parameter int CHAN_N = 4
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       conv_done,
    input  logic [CHAN_N*2*BYTE_W-1:0] conv_result,
    input  logic                       rd_stb,
    input  logic [ADR_W-1:0]           addr,
    output logic [BYTE_W-1:0]          res_byte
);

    localparam int RES_W = 2 * BYTE_W;

    logic [CHAN_N-1:0][BYTE_W-1:0] lo_sel;
    logic [CHAN_N-1:0][BYTE_W-1:0] hi_sel;

    for (genvar ch = 0; ch < CHAN_N; ch++) begin : g_chan
        localparam logic [ADR_W-1:0] LO_A = ADR_W'(int'(A_RES_BASE) + 2*ch);
        localparam logic [ADR_W-1:0] HI_A = ADR_W'(int'(A_RES_BASE) + 2*ch + 1);

        logic [RES_W-1:0]  res_q;
        logic [BYTE_W-1:0] shadow_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                res_q <= '0;
            else if (conv_done)
                res_q <= conv_result[ch*RES_W +: RES_W];
        end

        // the high byte paired with the low byte being returned
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                shadow_q <= '0;
            else if (rd_stb && (addr == LO_A))
                shadow_q <= res_q[RES_W-1:BYTE_W];
        end

        assign lo_sel[ch] = (addr == LO_A) ? res_q[BYTE_W-1:0] : '0;
        assign hi_sel[ch] = (addr == HI_A) ? shadow_q : '0;
    end

    always_comb begin
        res_byte = '0;
        for (int ch = 0; ch < CHAN_N; ch++)
            res_byte = res_byte | lo_sel[ch] | hi_sel[ch];
    end

endmodule

// File: rtl/cmd_regbank.sv
module cmd_regbank
    import cmd_regctl_pkg::*;
#(
    parameter logic [BYTE_W-1:0] DEV_ID = 8'hA4
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADR_W-1:0]  addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rd_stb,
    input  logic [BYTE_W-1:0] res_byte,
    input  logic              conv_done,
    input  logic              event_set,
    input  logic              irq_clr,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              cfg_power_on,
    output logic              cfg_conv_en,
    output logic              cfg_wait_en,
    output logic              cfg_irq_en,
    output logic [BYTE_W-1:0] cfg_int_time,
    output logic [BYTE_W-1:0] cfg_wait_time,
    output logic              cfg_wait_long,
    output logic [2*BYTE_W-1:0] cfg_low_thr,
    output logic [2*BYTE_W-1:0] cfg_high_thr,
    output logic [3:0]        cfg_persist,
    output logic [1:0]        cfg_gain,
    output logic              irq
);

    logic valid_q;
    logic pend_q;
    logic [BYTE_W-1:0] rd_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_power_on  <= 1'b0;
            cfg_conv_en   <= 1'b0;
            cfg_wait_en   <= 1'b0;
            cfg_irq_en    <= 1'b0;
            cfg_int_time  <= '1;
            cfg_wait_time <= '1;
            cfg_wait_long <= 1'b0;
            cfg_low_thr   <= '0;
            cfg_high_thr  <= '0;
            cfg_persist   <= '0;
            cfg_gain      <= '0;
        end else if (we) begin
            case (addr)
                A_ENABLE: begin
                    cfg_irq_en   <= wdata[4];
                    cfg_wait_en  <= wdata[3];
                    cfg_conv_en  <= wdata[1];
                    cfg_power_on <= wdata[0];
                end
                A_ITIME:   cfg_int_time  <= wdata;
                A_WTIME:   cfg_wait_time <= wdata;
                A_LTHR_LO: cfg_low_thr[BYTE_W-1:0]         <= wdata;
                A_LTHR_HI: cfg_low_thr[2*BYTE_W-1:BYTE_W]  <= wdata;
                A_HTHR_LO: cfg_high_thr[BYTE_W-1:0]        <= wdata;
                A_HTHR_HI: cfg_high_thr[2*BYTE_W-1:BYTE_W] <= wdata;
                A_PERSIST: cfg_persist   <= wdata[3:0];
                A_WLONG:   cfg_wait_long <= wdata[1];
                A_GAIN:    cfg_gain      <= wdata[1:0];
                default: ;
            endcase
        end
    end

    // status flags: a new event wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            if (conv_done)
                valid_q <= 1'b1;
            if (event_set)
                pend_q <= 1'b1;
            else if (irq_clr)
                pend_q <= 1'b0;
        end
    end

    assign irq = pend_q & cfg_irq_en;

    always_comb begin
        case (addr)
            A_ENABLE:  rd_val = {3'b000, cfg_irq_en, cfg_wait_en, 1'b0, cfg_conv_en, cfg_power_on};
            A_ITIME:   rd_val = cfg_int_time;
            A_WTIME:   rd_val = cfg_wait_time;
            A_LTHR_LO: rd_val = cfg_low_thr[BYTE_W-1:0];
            A_LTHR_HI: rd_val = cfg_low_thr[2*BYTE_W-1:BYTE_W];
            A_HTHR_LO: rd_val = cfg_high_thr[BYTE_W-1:0];
            A_HTHR_HI: rd_val = cfg_high_thr[2*BYTE_W-1:BYTE_W];
            A_PERSIST: rd_val = {4'b0000, cfg_persist};
            A_WLONG:   rd_val = {6'b000000, cfg_wait_long, 1'b0};
            A_GAIN:    rd_val = {6'b000000, cfg_gain};
            A_IDENT:   rd_val = DEV_ID;
            A_STATUS:  rd_val = {3'b000, pend_q, 3'b000, valid_q};
            default:   rd_val = res_byte;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_byte <= '0;
        else if (rd_stb)
            rd_byte <= rd_val;
    end

endmodule

// File: rtl/cmd_regctl.sv
module cmd_regctl
    import cmd_regctl_pkg::*;
#(
    parameter int                CHAN_N = 4,
    parameter logic [BYTE_W-1:0] DEV_ID = 8'hA4
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       txn_start,
    input  logic                       wr_stb,
    input  logic [7:0]                 wr_byte,
    input  logic                       rd_stb,
    output logic [7:0]                 rd_byte,
    input  logic                       conv_done,
    input  logic [CHAN_N*16-1:0]       conv_result,
    input  logic                       event_set,
    output logic                       cfg_power_on,
    output logic                       cfg_conv_en,
    output logic                       cfg_wait_en,
    output logic                       cfg_irq_en,
    output logic [7:0]                 cfg_int_time,
    output logic [7:0]                 cfg_wait_time,
    output logic                       cfg_wait_long,
    output logic [15:0]                cfg_low_thr,
    output logic [15:0]                cfg_high_thr,
    output logic [3:0]                 cfg_persist,
    output logic [1:0]                 cfg_gain,
    output logic                       irq
);

    logic              data_we;
    logic              irq_clr;
    logic [ADR_W-1:0]  cur_addr;
    logic [BYTE_W-1:0] res_byte;

    cmd_seq i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .txn_start (txn_start),
        .wr_stb    (wr_stb),
        .wr_byte   (wr_byte),
        .rd_stb    (rd_stb),
        .data_we   (data_we),
        .irq_clr   (irq_clr),
        .ptr       (cur_addr)
    );

    res_shadow #(.CHAN_N(CHAN_N)) i_res (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .rd_stb      (rd_stb),
        .addr        (cur_addr),
        .res_byte    (res_byte)
    );

    cmd_regbank #(.DEV_ID(DEV_ID)) i_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .we            (data_we),
        .addr          (cur_addr),
        .wdata         (wr_byte),
        .rd_stb        (rd_stb),
        .res_byte      (res_byte),
        .conv_done     (conv_done),
        .event_set     (event_set),
        .irq_clr       (irq_clr),
        .rd_byte       (rd_byte),
        .cfg_power_on  (cfg_power_on),
        .cfg_conv_en   (cfg_conv_en),
        .cfg_wait_en   (cfg_wait_en),
        .cfg_irq_en    (cfg_irq_en),
        .cfg_int_time  (cfg_int_time),
        .cfg_wait_time (cfg_wait_time),
        .cfg_wait_long (cfg_wait_long),
        .cfg_low_thr   (cfg_low_thr),
        .cfg_high_thr  (cfg_high_thr),
        .cfg_persist   (cfg_persist),
        .cfg_gain      (cfg_gain),
        .irq           (irq)
    );

endmodule

// File: rtl/cmd_regctl_checker.sv
module cmd_regctl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_stb,
    input logic       rd_stb,
    input logic       event_set,
    input logic       irq,
    input logic       cfg_irq_en,
    input logic [7:0] rd_byte,
    input logic [7:0] cfg_int_time,
    input logic [7:0] cfg_wait_time,
    input logic [15:0] cfg_low_thr,
    input logic [15:0] cfg_high_thr,
    input logic [4:0] ptr
);

    // R9: the interrupt pin only asserts while the enable field is set
    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cfg_irq_en);

    // R9: a new interrupt needs an event or a register write one cycle before
    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(event_set) || $past(wr_stb)));

    // R5: only a written byte can drop the interrupt
    assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq) && !$past(wr_stb)) |-> irq);

    // R10: configuration moves only after a written byte
    assert_cfg_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_stb) |-> ($stable(cfg_int_time) && $stable(cfg_wait_time)
                            && $stable(cfg_low_thr) && $stable(cfg_high_thr)));

    // R12: returned byte is held between reads
    assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_stb) |-> $stable(rd_byte));

    // R3: the stored address moves only on a byte transfer
    assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_stb) && !$past(rd_stb)) |-> $stable(ptr));

endmodule

bind cmd_regctl cmd_regctl_checker i_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_stb        (wr_stb),
    .rd_stb        (rd_stb),
    .event_set     (event_set),
    .irq           (irq),
    .cfg_irq_en    (cfg_irq_en),
    .rd_byte       (rd_byte),
    .cfg_int_time  (cfg_int_time),
    .cfg_wait_time (cfg_wait_time),
    .cfg_low_thr   (cfg_low_thr),
    .cfg_high_thr  (cfg_high_thr),
    .ptr           (cur_addr)
);

// File: tb/test_cmd_regctl.sv
module test_cmd_regctl;

    localparam logic [7:0] ID_VAL = 8'hA4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        txn_start = 1'b0;
    logic        wr_stb = 1'b0;
    logic [7:0]  wr_byte = 8'h00;
    logic        rd_stb = 1'b0;
    logic [7:0]  rd_byte;
    logic        conv_done = 1'b0;
    logic [63:0] conv_result = '0;
    logic        event_set = 1'b0;
    logic        cfg_power_on, cfg_conv_en, cfg_wait_en, cfg_irq_en;
    logic [7:0]  cfg_int_time, cfg_wait_time;
    logic        cfg_wait_long;
    logic [15:0] cfg_low_thr, cfg_high_thr;
    logic [3:0]  cfg_persist;
    logic [1:0]  cfg_gain;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    cmd_regctl #(.CHAN_N(4), .DEV_ID(ID_VAL)) i_cmd_regctl (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .wr_stb(wr_stb),
        .wr_byte(wr_byte), .rd_stb(rd_stb), .rd_byte(rd_byte),
        .conv_done(conv_done), .conv_result(conv_result), .event_set(event_set),
        .cfg_power_on(cfg_power_on), .cfg_conv_en(cfg_conv_en),
        .cfg_wait_en(cfg_wait_en), .cfg_irq_en(cfg_irq_en),
        .cfg_int_time(cfg_int_time), .cfg_wait_time(cfg_wait_time),
        .cfg_wait_long(cfg_wait_long), .cfg_low_thr(cfg_low_thr),
        .cfg_high_thr(cfg_high_thr), .cfg_persist(cfg_persist),
        .cfg_gain(cfg_gain), .irq(irq)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic start();
        @(negedge clk) txn_start = 1'b1;
        @(negedge clk) txn_start = 1'b0;
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk) begin wr_stb = 1'b1; wr_byte = b; end
        @(negedge clk) wr_stb = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] exp);
        @(negedge clk) rd_stb = 1'b1;
        @(negedge clk) rd_stb = 1'b0;
        check(tag, {8'h00, rd_byte}, {8'h00, exp});
    endtask

    task automatic pulse_conv(input logic [63:0] v);
        @(negedge clk) begin conv_result = v; conv_done = 1'b1; end
        @(negedge clk) conv_done = 1'b0;
    endtask

    task automatic pulse_event();
        @(negedge clk) event_set = 1'b1;
        @(negedge clk) event_set = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 irq", {15'd0, irq}, 16'h0);
        check("R1 itime port", {8'h00, cfg_int_time}, 16'h00FF);
        start(); wr(8'h81); rd("R1 itime", 8'hFF);
        start(); wr(8'h83); rd("R1 wtime", 8'hFF);
        start(); wr(8'h80); rd("R1 enable", 8'h00);
        start(); wr(8'h92); rd("R1 ident", ID_VAL);
        start(); wr(8'h93); rd("R1 status", 8'h00);
        start(); wr(8'h84); rd("R1 low thr", 8'h00);
    endtask

    task automatic t_config();
        start(); wr(8'hA0); wr(8'hFF); wr(8'h3C);
        check("R11 enable fields", {12'h0, cfg_irq_en, cfg_wait_en, cfg_conv_en, cfg_power_on}, 16'h000F);
        check("R2 itime via stream", {8'h00, cfg_int_time}, 16'h003C);
        start(); wr(8'h80); rd("R11 enable reserved", 8'h1B);
        start(); wr(8'h81); start(); wr(8'h22);
        check("R2 first byte as data", {8'h00, cfg_int_time}, 16'h0022);
    endtask

    task automatic t_repeat();
        start(); wr(8'h84); wr(8'h11); wr(8'h22);
        check("R3 repeat write", cfg_low_thr, 16'h0022);
        rd("R3 repeat read a", 8'h22);
        rd("R3 repeat read b", 8'h22);
    endtask

    task automatic t_incr();
        start(); wr(8'hA4); wr(8'h11); wr(8'h22); wr(8'h33); wr(8'h44);
        check("R4 low thr", cfg_low_thr, 16'h2211);
        check("R11 high thr", cfg_high_thr, 16'h4433);
        start(); wr(8'hBF);
        rd("R4 unmapped 0x1F", 8'h00);
        rd("R4 wrap to 0x00", 8'h1B);
    endtask

    task automatic t_prev_addr();
        start(); wr(8'h83); wr(8'h40);
        check("R6 wtime port", {8'h00, cfg_wait_time}, 16'h0040);
        start(); rd("R6 no command read", 8'h40);
        start(); rd("R6 second transaction", 8'h40);
    endtask

    task automatic t_reserved();
        start(); wr(8'hAC); wr(8'hFF); wr(8'hFF); wr(8'hFF); wr(8'hFF);
        check("R11 persist", {12'h0, cfg_persist}, 16'h000F);
        check("R11 long wait", {15'd0, cfg_wait_long}, 16'h0001);
        check("R11 gain", {14'd0, cfg_gain}, 16'h0003);
        start(); wr(8'hAC);
        rd("R11 persist rb", 8'h0F);
        rd("R11 wlong rb", 8'h02);
        rd("R10 unmapped rb", 8'h00);
        rd("R11 gain rb", 8'h03);
    endtask

    task automatic t_results();
        pulse_conv(64'hDEF0_9ABC_5678_1234);
        start(); wr(8'hB4);
        rd("R8 clear lo", 8'h34); rd("R8 clear hi", 8'h12);
        rd("R8 red lo", 8'h78);   rd("R8 red hi", 8'h56);
        rd("R8 green lo", 8'hBC); rd("R8 green hi", 8'h9A);
        rd("R8 blue lo", 8'hF0);  rd("R8 blue hi", 8'hDE);
        start(); wr(8'h93); rd("R8 status valid", 8'h01);
    endtask

    task automatic t_shadow();
        start(); wr(8'hB4);
        rd("R7 lo before conv", 8'h34);
        pulse_conv(64'hDEF0_9ABC_5678_AB99);
        rd("R7 hi from shadow", 8'h12);
        start(); wr(8'hB4);
        rd("R7 new lo", 8'h99);
        rd("R7 new hi", 8'hAB);
    endtask

    task automatic t_irq();
        pulse_event();
        check("R9 irq set", {15'd0, irq}, 16'h1);
        start(); wr(8'h93); rd("R9 status pending", 8'h11);
        start(); wr(8'hE0);
        check("R5 nop keeps irq", {15'd0, irq}, 16'h1);
        start(); wr(8'hC6);
        check("R5 reserved type keeps irq", {15'd0, irq}, 16'h1);
        start(); rd("R5 address kept", 8'h11);
        start(); wr(8'hE6);
        check("R5 clear", {15'd0, irq}, 16'h0);
        start(); rd("R5 status after clear", 8'h01);
        start(); wr(8'h81);
        start(); wr(8'hE6); wr(8'h55);
        check("R5 data after special dropped", {8'h00, cfg_int_time}, 16'h0022);
        start(); rd("R5 pointer kept", 8'h22);
        start(); wr(8'h80); wr(8'h0B);
        pulse_event();
        check("R9 gated irq", {15'd0, irq}, 16'h0);
        start(); wr(8'h93); rd("R9 pending while gated", 8'h11);
        start(); wr(8'h80); wr(8'h1B);
        check("R9 irq on reenable", {15'd0, irq}, 16'h1);
        start(); wr(8'hE6);
        check("R9 cleared", {15'd0, irq}, 16'h0);
    endtask

    task automatic t_readonly();
        start(); wr(8'h92); wr(8'h77);
        start(); rd("R10 ident write ignored", ID_VAL);
        start(); wr(8'h93); wr(8'h00);
        start(); rd("R10 status write ignored", 8'h01);
        start(); wr(8'h94); wr(8'h55);
        start(); wr(8'h94); rd("R10 result write ignored", 8'h99);
        start(); wr(8'h82); wr(8'h66);
        start(); rd("R10 unmapped write", 8'h00);
        check("R12 rd_byte held", {8'h00, rd_byte}, 16'h0000);
    endtask

    initial begin
        #(200000 * 20);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_config();
        t_repeat();
        t_incr();
        t_prev_addr();
        t_reserved();
        t_results();
        t_shadow();
        t_irq();
        t_readonly();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule